// File: doc/BRIEF.md
# Clock Gate Enable Register Bank

This block turns clocks on and off under software control through a small register port. It holds two independent groups of gates. The system group drives a handful of clocks, such as the USB device and host clocks and four programmable clock outputs. Each of these clocks has its own source clock input. The peripheral group drives up to 32 clocks that all come from the block's main clock. Each peripheral is addressed by the bit at its peripheral ID, so one write can name several peripherals as a one-hot or multi-hot mask.

Each group has three registers. The first is a set strobe, where a 1 in a bit turns that clock on. The second is a clear strobe, where a 1 in a bit turns that clock off. The third is a read-only state word. Nothing is read and then rewritten. Software names only the bits it wants to change, so two drivers can update neighbouring clocks without racing each other. The gate control is copied into a register on the falling edge of the clock it gates. Each output clock is the AND of that source clock and the copied control. An enable change therefore only takes effect while the source clock is low.

The register port is plain. A write is taken on a rising edge of `clk` when `bus_wr` is high. Read data is a combinational function of `bus_addr`. There is no stream interface, so no back-pressure rule applies.

Top module: `clkgate_ctrl`

## Requirements
- R1: After reset, the system state is `SYS_RST` (default all off) and the peripheral state is `PER_RST` (default 0x0000_0003). The gate enables follow these values from the first falling edge after reset is released.
- R2: A write to the system set register (word address 0) or to the peripheral set register (word address 4) turns on every clock whose data bit is 1. Clocks whose data bit is 0 keep their state. The new state is visible at the status register right after the rising edge that took the write.
- R3: A write to the system clear register (address 1) or to the peripheral clear register (address 5) turns off every clock whose data bit is 1, including several at once. Clocks whose data bit is 0 keep their state.
- R4: Data bits above the width of a group (bit 6 and up for the system group) have no effect.
- R5: The system status register (address 2) and the peripheral status register (address 6) return the current state in the low bits, with zeros above. Writes to these registers change nothing.
- R6: Reads of the set and clear registers (addresses 0, 1, 4, 5) return zero.
- R7: The groups are independent. A write to a peripheral register leaves the system state unchanged, and the reverse also holds.
- R8: A gate enable output takes a new state at the first falling edge of its source clock after the state changes. The gated clock equals the source clock ANDed with that enable, so it is low whenever its source clock is low.
- R9: Addresses 3 and 7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock and source of the peripheral clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_src_clk | input | N_SYS | Source clock of each system gate |
| bus_wr | input | 1 | Write strobe, taken on a rising edge of clk |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| sys_gate_en | output | N_SYS | System gate enables, registered on the falling edge of the source clock |
| sys_gclk | output | N_SYS | Gated system clocks |
| per_gate_en | output | N_PER | Peripheral gate enables, registered on the falling edge of clk |
| per_gclk | output | N_PER | Gated peripheral clocks |

## Verification
The state update is driven by a table of writes that covers several patterns:
- set masks with scattered bits, which show that untouched bits are kept;
- multi-bit clear masks that partly overlap clocks already on, which separate clear-with-mask from clear-all;
- all-zero masks, which show that a 0 bit has no effect;
- all-ones writes to the status registers and to the unmapped addresses, which show that these writes are ignored;
- system writes with data only above bit 5, which show that out-of-range bits are ignored.

After each write, both status words and both enable buses are compared. This keeps the two groups apart. Directed tests then check the reset image, that the set and clear registers read as zero, and when the enable and the gated clock change relative to the falling edge.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_SYS_SET  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SYS_CLR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SYS_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_PER_SET  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PER_CLR  = 3'd5;
  localparam logic [ADDR_W-1:0] A_PER_STAT = 3'd6;
endpackage

// File: rtl/cg_reg_decode.sv
module cg_reg_decode
  import clkgate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_SYS  = 6,
  parameter int N_PER  = 32
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N_SYS-1:0]  sys_state,
  input  logic [N_PER-1:0]  per_state,
  output logic [N_SYS-1:0]  sys_set,
  output logic [N_SYS-1:0]  sys_clr,
  output logic [N_PER-1:0]  per_set,
  output logic [N_PER-1:0]  per_clr,
  output logic [DATA_W-1:0] bus_rdata
);
  // Only the low bits of each group are used; the rest are dropped on purpose.
  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    sys_set = '0;
    sys_clr = '0;
    per_set = '0;
    per_clr = '0;
    if (bus_wr) begin
      case (bus_addr)
        A_SYS_SET: sys_set = bus_wdata[N_SYS-1:0];
        A_SYS_CLR: sys_clr = bus_wdata[N_SYS-1:0];
        A_PER_SET: per_set = bus_wdata[N_PER-1:0];
        A_PER_CLR: per_clr = bus_wdata[N_PER-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SYS_STAT: bus_rdata[N_SYS-1:0] = sys_state;
      A_PER_STAT: bus_rdata[N_PER-1:0] = per_state;
      default: ;
    endcase
  end
endmodule

// File: rtl/cg_gate_state.sv
module cg_gate_state #(
  parameter int         W       = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] state
);
  // Clear is applied after set, so a bit named in both ends up off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RST_VAL;
    else        state <= (state | set) & ~clr;
  end
endmodule

// File: rtl/cg_gate_cell.sv
module cg_gate_cell (
  input  logic src_clk,
  input  logic rst_n,
  input  logic en_req,
  output logic en_q,
  output logic gclk
);
  // Enable only moves while the source is low, so the AND cannot glitch.
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_req;
  end
  assign gclk = src_clk & en_q;
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int               DATA_W  = 32,
  parameter int               N_SYS   = 6,
  parameter int               N_PER   = 32,
  parameter logic [N_SYS-1:0] SYS_RST = '0,
  parameter logic [N_PER-1:0] PER_RST = 32'h0000_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SYS-1:0]  sys_src_clk,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_SYS-1:0]  sys_gate_en,
  output logic [N_SYS-1:0]  sys_gclk,
  output logic [N_PER-1:0]  per_gate_en,
  output logic [N_PER-1:0]  per_gclk
);
  logic [N_SYS-1:0] sys_set, sys_clr, sys_state;
  logic [N_PER-1:0] per_set, per_clr, per_state;

  cg_reg_decode #(.DATA_W(DATA_W), .N_SYS(N_SYS), .N_PER(N_PER)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .sys_state(sys_state), .per_state(per_state),
    .sys_set(sys_set), .sys_clr(sys_clr),
    .per_set(per_set), .per_clr(per_clr),
    .bus_rdata(bus_rdata)
  );

  cg_gate_state #(.W(N_SYS), .RST_VAL(SYS_RST)) u_sys_state (
    .clk(clk), .rst_n(rst_n), .set(sys_set), .clr(sys_clr), .state(sys_state)
  );

  cg_gate_state #(.W(N_PER), .RST_VAL(PER_RST)) u_per_state (
    .clk(clk), .rst_n(rst_n), .set(per_set), .clr(per_clr), .state(per_state)
  );

  for (genvar i = 0; i < N_SYS; i++) begin : g_sys
    cg_gate_cell u_cell (
      .src_clk(sys_src_clk[i]), .rst_n(rst_n), .en_req(sys_state[i]),
      .en_q(sys_gate_en[i]), .gclk(sys_gclk[i])
    );
  end

  for (genvar j = 0; j < N_PER; j++) begin : g_per
    cg_gate_cell u_cell (
      .src_clk(clk), .rst_n(rst_n), .en_req(per_state[j]),
      .en_q(per_gate_en[j]), .gclk(per_gclk[j])
    );
  end
endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk
  import clkgate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_SYS  = 6,
  parameter int N_PER  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_SYS-1:0]  sys_state,
  input logic [N_PER-1:0]  per_state,
  input logic [N_PER-1:0]  per_gclk
);
  // R2
  per_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PER_SET) |=>
      ((per_state & $past(bus_wdata[N_PER-1:0])) == $past(bus_wdata[N_PER-1:0])));

  // R2
  sys_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SYS_SET) |=>
      ((sys_state & $past(bus_wdata[N_SYS-1:0])) == $past(bus_wdata[N_SYS-1:0])));

  // R3
  per_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PER_CLR) |=>
      ((per_state & $past(bus_wdata[N_PER-1:0])) == '0));

  // R7
  group_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[2]) |=> $stable(sys_state));

  // R6
  strobe_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_SYS_SET || bus_addr == A_SYS_CLR ||
     bus_addr == A_PER_SET || bus_addr == A_PER_CLR) |-> (bus_rdata == '0));

  // R8
  gclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_gclk == '0);
endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(.DATA_W(DATA_W), .N_SYS(N_SYS), .N_PER(N_PER)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_state(sys_state),
  .per_state(per_state), .per_gclk(per_gclk)
);

// File: tb/clkgate_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkgate_ctrl_tb_top;
  localparam int DATA_W = 32;
  localparam int N_SYS  = 6;
  localparam int N_PER  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [2:0]        bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [N_SYS-1:0]  sys_gate_en, sys_gclk;
  logic [N_PER-1:0]  per_gate_en, per_gclk;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  clkgate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sys_src_clk({N_SYS{clk}}),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sys_gate_en(sys_gate_en), .sys_gclk(sys_gclk),
    .per_gate_en(per_gate_en), .per_gclk(per_gclk)
  );

  // {addr, wdata, expected sys state, expected peripheral state}
  localparam logic [72:0] VEC [12] = '{
    {3'd4, 32'h0000_1230, 6'h00, 32'h0000_1233},  // R2 scattered set
    {3'd0, 32'h0000_0025, 6'h25, 32'h0000_1233},  // R2 R7
    {3'd1, 32'h0000_0004, 6'h21, 32'h0000_1233},  // R3 R7
    {3'd5, 32'h0000_0231, 6'h21, 32'h0000_1002},  // R3 multi-bit clear
    {3'd4, 32'h0000_0000, 6'h21, 32'h0000_1002},  // R2 zero mask
    {3'd6, 32'hFFFF_FFFF, 6'h21, 32'h0000_1002},  // R5 status write ignored
    {3'd3, 32'hFFFF_FFFF, 6'h21, 32'h0000_1002},  // R9
    {3'd7, 32'hFFFF_FFFF, 6'h21, 32'h0000_1002},  // R9
    {3'd0, 32'h0000_0FC0, 6'h21, 32'h0000_1002},  // R4 high bits only
    {3'd4, 32'h8000_0000, 6'h21, 32'h8000_1002},  // R2 top peripheral
    {3'd1, 32'h0000_003F, 6'h00, 32'h8000_1002},  // R3 R7
    {3'd5, 32'hFFFF_FFFF, 6'h00, 32'h0000_0000}   // R3 clear all
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    bus_read(3'd2, rd); check("R1 sys status", rd, 32'h0);
    bus_read(3'd6, rd); check("R1 per status", rd, 32'h3);
    @(negedge clk); #1;
    check("R1 per gate_en", per_gate_en, 32'h3);
    check("R1 sys gate_en", {26'h0, sys_gate_en}, 32'h0);
    @(posedge clk); #1;

    for (int i = 0; i < 12; i++) begin
      bus_write(VEC[i][72:70], VEC[i][69:38]);
      bus_read(3'd2, rd); check($sformatf("R2/R3/R7 vec%0d sys", i), rd, {26'h0, VEC[i][37:32]});
      bus_read(3'd6, rd); check($sformatf("R2/R3/R7 vec%0d per", i), rd, VEC[i][31:0]);
      @(negedge clk); #1;
      check($sformatf("R8 vec%0d per gate_en", i), per_gate_en, VEC[i][31:0]);
      check($sformatf("R8 vec%0d sys gate_en", i), {26'h0, sys_gate_en}, {26'h0, VEC[i][37:32]});
      @(posedge clk); #1;
    end

    // R6 strobe registers read zero while state is nonzero
    bus_write(3'd4, 32'h0000_00F0);
    bus_write(3'd0, 32'h0000_0011);
    bus_read(3'd0, rd); check("R6 sys set reads 0", rd, 32'h0);
    bus_read(3'd1, rd); check("R6 sys clr reads 0", rd, 32'h0);
    bus_read(3'd4, rd); check("R6 per set reads 0", rd, 32'h0);
    bus_read(3'd5, rd); check("R6 per clr reads 0", rd, 32'h0);
    bus_read(3'd3, rd); check("R9 addr3 reads 0", rd, 32'h0);
    bus_read(3'd7, rd); check("R9 addr7 reads 0", rd, 32'h0);
    bus_read(3'd2, rd); check("R5 sys status", rd, 32'h11);

    // R8 enable timing and gated clock shape
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h0000_0100;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
    check("R8 en not yet moved", {31'h0, per_gate_en[8]}, 32'h0);
    check("R8 gclk follows old en", per_gclk, 32'h0000_00F0);
    @(negedge clk); #1;
    check("R8 en moved at fall", {31'h0, per_gate_en[8]}, 32'h1);
    check("R8 gclk low while clk low", per_gclk, 32'h0);
    check("R8 sys gclk low", {26'h0, sys_gclk}, 32'h0);
    @(posedge clk); #1;
    check("R8 gclk high with en", per_gclk, 32'h0000_01F0);
    check("R8 sys gclk high", {26'h0, sys_gclk}, 32'h11);

    finish_run();
  end
endmodule